// File: doc/BRIEF.md
# Floating-Point to 32-bit Integer Converter

This unit turns one floating-point operand, in single or double precision, into a signed or unsigned 32-bit integer. The operand is presented as a raw bit pattern together with a format select, a signedness select, a 3-bit rounding-mode field and the dynamic rounding mode currently held in the floating-point status register. One clock edge after an accepted request the unit presents the integer, already widened to the full register width, along with a result write strobe. It also presents a five-bit exception vector and a separate strobe that asks for the vector to be merged into the status register.

Values that cannot be represented are clamped by fixed rules rather than wrapped. NaN and large positive inputs give the largest value of the target type, and large negative inputs give the smallest. One case is special: a small negative value converted to an unsigned target gives zero with only the inexact flag. If the requested or dynamic rounding mode is not a legal encoding, the conversion is dropped: nothing is written and an error pulse is raised instead.

Top module: `fcvt_to_int`

## Requirements
- R1: A NaN operand (exponent all ones, fraction nonzero, either sign) gives the target maximum (0x7FFFFFFF signed, 0xFFFFFFFF unsigned) with only the invalid flag.
- R2: A non-negative operand whose value is greater than or equal to the target maximum, including +infinity and an exact 2147483647.0 for a signed target, gives the maximum with only the invalid flag.
- R3: A negative operand below the target minimum gives the minimum (0x80000000 signed, 0 unsigned) with only the invalid flag; for an unsigned target, every negative value of magnitude one or more falls here, -infinity included.
- R4: For an unsigned target, a negative nonzero operand of magnitude below one gives 0 with only the inexact flag, whatever the rounding mode.
- R5: +0 and -0 give 0 with no flag set and the flags strobe low.
- R6: In-range operands are rounded by the active mode, with the encodings 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity and 4 nearest with ties away from zero; the inexact flag is set exactly when a nonzero fraction was discarded.
- R7: The 32-bit result is sign-extended from its bit 31 to the full XLEN width, for unsigned targets as well.
- R8: The flags vector has invalid at bit 4 and inexact at bit 0, all other bits zero; the flags strobe is high only when at least one flag is set.
- R9: A rounding-mode field of 7 selects the dynamic mode input; any other legal field value is used directly.
- R10: An effective mode of 5, 6 or 7 drops the operation: the error output pulses and neither the result strobe nor the flags strobe is raised.
- R11: A request sampled with in_valid high produces its strobes on the next clock edge for exactly one cycle; with in_valid low all three strobes stay low.
- R12: Format select 1 reads a double from op[63:0]; format select 0 reads a single from op[31:0] and ignores op[63:32].
- R13: While reset is asserted (rst_n low) all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted on this edge |
| op | input | 64 | Raw floating-point bit pattern |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| is_unsigned | input | 1 | 1 = unsigned target, 0 = signed target |
| rm_field | input | 3 | Rounding mode from the operation; 7 = use dynamic |
| dyn_rm | input | 3 | Dynamic rounding mode from the status register |
| result | output | XLEN | Sign-extended integer result |
| res_we | output | 1 | Result write strobe |
| flags | output | 5 | Exception vector (invalid bit 4, inexact bit 0) |
| flags_we | output | 1 | Flags merge strobe |
| rm_err | output | 1 | Illegal rounding mode, operation dropped |

## Verification
The bench builds the unit with its defaults, a 64-bit register width and a 32-bit integer target, so that sign extension of unsigned results into the upper word is visible on every write. At these widths double inputs reach both saturation edges exactly, at 2147483647.0, -2147483648.0 and 4294967295.0, as well as ties at every rounding mode near zero and near the limits. Single inputs exercise the padded-significand path and the ignored upper half of the operand.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4,
    RM_DYNAMIC   = 3'd7
  } rmode_e;

  localparam int FLG_W  = 5;
  localparam int FLG_NV = 4;
  localparam int FLG_NX = 0;
  localparam int SIG_W  = 53;   // double significand with hidden bit
  localparam int EXP_W  = 13;   // signed unbiased exponent

  typedef struct packed {
    logic                    is_nan;
    logic                    is_inf;
    logic                    is_zero;
    logic                    is_sub;
    logic                    neg;
    logic signed [EXP_W-1:0] uexp;
    logic [SIG_W-1:0]        sig;
  } fp_unpk_t;

  function automatic logic mode_legal(input logic [2:0] m);
    return m <= 3'd4;
  endfunction

  // Decides whether the truncated magnitude must be bumped by one.
  function automatic logic round_bump(input logic [2:0] m, input logic neg,
                                      input logic lsb, input logic half,
                                      input logic rest);
    case (m)
      RM_NEAR_EVEN: return half & (rest | lsb);
      RM_ZERO:      return 1'b0;
      RM_DOWN:      return neg & (half | rest);
      RM_UP:        return ~neg & (half | rest);
      RM_NEAR_MAX:  return half;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [63:0] op,
  input  logic        fmt_dbl,
  output fp_unpk_t    unpk
);
  logic [10:0] exp_d;
  logic [51:0] frac_d;
  logic [7:0]  exp_s;
  logic [22:0] frac_s;
  logic        exp_max, exp_min, frac_nz;

  always_comb begin
    exp_d  = op[62:52];
    frac_d = op[51:0];
    exp_s  = op[30:23];
    frac_s = op[22:0];
    unpk   = '0;
    if (fmt_dbl) begin
      exp_max   = &exp_d;
      exp_min   = ~|exp_d;
      frac_nz   = |frac_d;
      unpk.neg  = op[63];
      unpk.uexp = $signed({2'b00, exp_d}) - 13'sd1023;
      unpk.sig  = {~exp_min, frac_d};
    end else begin
      exp_max   = &exp_s;
      exp_min   = ~|exp_s;
      frac_nz   = |frac_s;
      unpk.neg  = op[31];
      unpk.uexp = $signed({5'b00000, exp_s}) - 13'sd127;
      unpk.sig  = {~exp_min, frac_s, 29'b0};
    end
    unpk.is_nan  = exp_max & frac_nz;
    unpk.is_inf  = exp_max & ~frac_nz;
    unpk.is_zero = exp_min & ~frac_nz;
    unpk.is_sub  = exp_min & frac_nz;
  end
endmodule

// File: rtl/fcvt_rm_sel.sv
module fcvt_rm_sel
  import fcvt_pkg::*;
(
  input  logic [2:0] rm_field,
  input  logic [2:0] dyn_rm,
  output logic [2:0] eff_rm,
  output logic       rm_ok
);
  always_comb begin
    eff_rm = (rm_field == RM_DYNAMIC) ? dyn_rm : rm_field;
    rm_ok  = mode_legal(eff_rm);
  end
endmodule

// File: rtl/fcvt_core.sv
module fcvt_core
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fp_unpk_t         unpk,
  input  logic             is_unsigned,
  input  logic [2:0]       rm,
  output logic [INT_W-1:0] res,
  output logic             nv,
  output logic             nx
);
  localparam int FRAC = 64;
  localparam int FXW  = FRAC + INT_W + 1;
  localparam logic signed [EXP_W-1:0] EBIG = EXP_W'(INT_W);
  localparam logic [INT_W:0] LIM_S   = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] LIM_U   = {1'b0, {INT_W{1'b1}}};
  localparam logic [INT_W:0] NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_S = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_S = {1'b1, {(INT_W-1){1'b0}}};

  logic [FXW-1:0]   fx;
  logic [EXP_W-1:0] shamt;
  logic [INT_W:0]   ipart;
  logic             half, rest, big, bump;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] sat_max;

  // Fixed-point alignment: integer part, half bit and sticky rest.
  always_comb begin
    fx    = '0;
    ipart = '0;
    half  = 1'b0;
    rest  = 1'b0;
    shamt = unpk.uexp + 13'sd12;
    big   = unpk.is_inf | (unpk.uexp >= EBIG);
    if (unpk.is_sub) begin
      rest = 1'b1;
    end else if (unpk.uexp < 0) begin
      half = (unpk.uexp == -13'sd1);
      rest = (unpk.uexp < -13'sd1) | (|unpk.sig[SIG_W-2:0]);
    end else if (!big) begin
      fx    = FXW'(unpk.sig) << shamt;
      ipart = fx[FXW-1:FRAC];
      half  = fx[FRAC-1];
      rest  = |fx[FRAC-2:0];
    end
    bump    = round_bump(rm, unpk.neg, ipart[0], half, rest);
    mag     = ipart[INT_W-1:0] + INT_W'(bump);
    sat_max = is_unsigned ? {INT_W{1'b1}} : MAX_S;
  end

  // Saturation and sign application.
  always_comb begin
    res = '0;
    nv  = 1'b0;
    nx  = 1'b0;
    if (unpk.is_nan) begin
      res = sat_max;
      nv  = 1'b1;
    end else if (unpk.is_zero) begin
      res = '0;
    end else if (!unpk.neg && (big || ipart >= (is_unsigned ? LIM_U : LIM_S))) begin
      res = sat_max;
      nv  = 1'b1;
    end else if (unpk.neg && is_unsigned) begin
      if (!big && ipart == '0) nx = 1'b1;
      else                     nv = 1'b1;
    end else if (unpk.neg && (big || ipart > NEG_LIM ||
                              (ipart == NEG_LIM && (half || rest)))) begin
      res = MIN_S;
      nv  = 1'b1;
    end else begin
      res = unpk.neg ? (~mag + 1'b1) : mag;
      nx  = half | rest;
    end
  end
endmodule

// File: rtl/fcvt_to_int.sv
module fcvt_to_int
  import fcvt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int INT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [63:0]          op,
  input  logic                 fmt_dbl,
  input  logic                 is_unsigned,
  input  logic [2:0]           rm_field,
  input  logic [2:0]           dyn_rm,
  output logic [XLEN-1:0]      result,
  output logic                 res_we,
  output logic [FLG_W-1:0]     flags,
  output logic                 flags_we,
  output logic                 rm_err
);
  localparam int EXT_W = XLEN - INT_W;

  fp_unpk_t         unpk;
  logic [2:0]       eff_rm;
  logic             rm_ok;
  logic [INT_W-1:0] core_res;
  logic             core_nv, core_nx;
  logic [FLG_W-1:0] flag_vec;
  logic             accept, reject;

  fcvt_unpack u_unpack (.op(op), .fmt_dbl(fmt_dbl), .unpk(unpk));

  fcvt_rm_sel u_rm (.rm_field(rm_field), .dyn_rm(dyn_rm),
                    .eff_rm(eff_rm), .rm_ok(rm_ok));

  fcvt_core #(.INT_W(INT_W)) u_core (
    .unpk(unpk), .is_unsigned(is_unsigned), .rm(eff_rm),
    .res(core_res), .nv(core_nv), .nx(core_nx)
  );

  always_comb begin
    flag_vec         = '0;
    flag_vec[FLG_NV] = core_nv;
    flag_vec[FLG_NX] = core_nx;
    accept           = in_valid & rm_ok;
    reject           = in_valid & ~rm_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      flags    <= '0;
      res_we   <= 1'b0;
      flags_we <= 1'b0;
      rm_err   <= 1'b0;
    end else begin
      res_we   <= accept;
      flags_we <= accept & (|flag_vec);
      rm_err   <= reject;
      if (accept) begin
        result <= {{EXT_W{core_res[INT_W-1]}}, core_res};
        flags  <= flag_vec;
      end
    end
  end
endmodule

// File: rtl/fcvt_to_int_chk.sv
module fcvt_to_int_chk #(
  parameter int XLEN  = 64,
  parameter int INT_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [63:0]     op,
  input logic            fmt_dbl,
  input logic            is_unsigned,
  input logic [2:0]      rm_field,
  input logic [2:0]      dyn_rm,
  input logic [XLEN-1:0] result,
  input logic            res_we,
  input logic [4:0]      flags,
  input logic            flags_we,
  input logic            rm_err
);
  localparam logic [XLEN-1:0] SMAX = {{(XLEN-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};

  logic [2:0] mode_q;
  logic       mode_ok, nan_in, zero_in;

  always_comb begin
    mode_q  = (rm_field == 3'd7) ? dyn_rm : rm_field;
    mode_ok = (mode_q < 3'd5);
    nan_in  = fmt_dbl ? ((&op[62:52]) && (|op[51:0])) : ((&op[30:23]) && (|op[22:0]));
    zero_in = fmt_dbl ? (op[62:0] == '0) : (op[30:0] == '0);
  end

  a_r1_nan_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_ok && nan_in |=>
      res_we && flags == 5'b10000 &&
      result == ($past(is_unsigned) ? {XLEN{1'b1}} : SMAX));

  a_r5_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_ok && zero_in |=> res_we && result == '0 && !flags_we);

  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (result[XLEN-1:INT_W] == {(XLEN-INT_W){result[INT_W-1]}}));

  a_r8_layout: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> flags[3:1] == 3'b000);

  a_r8_strobe_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> res_we && flags != '0);

  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_ok |=> rm_err && !res_we && !flags_we);

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_we && !flags_we && !rm_err);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_we, rm_err}) <= 1);
endmodule

bind fcvt_to_int fcvt_to_int_chk #(.XLEN(XLEN), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt_dbl(fmt_dbl),
  .is_unsigned(is_unsigned), .rm_field(rm_field), .dyn_rm(dyn_rm),
  .result(result), .res_we(res_we), .flags(flags), .flags_we(flags_we),
  .rm_err(rm_err)
);

// File: tb/fcvt_to_int_bench.sv
module fcvt_to_int_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op;
  logic        fmt_dbl, is_unsigned;
  logic [2:0]  rm_field, dyn_rm;
  logic [63:0] result;
  logic        res_we, flags_we, rm_err;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fcvt_to_int u_fcvt_to_int (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt_dbl(fmt_dbl),
    .is_unsigned(is_unsigned), .rm_field(rm_field), .dyn_rm(dyn_rm),
    .result(result), .res_we(res_we), .flags(flags), .flags_we(flags_we),
    .rm_err(rm_err)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Value of the operand as a real number (finite inputs only).
  function automatic real val_of(input logic [63:0] b, input logic dbl);
    real v;
    if (dbl) return $bitstoreal(b);
    if (b[30:23] == 8'd0) v = real'(b[22:0]) * (2.0 ** (-149.0));
    else v = (real'(b[22:0]) + 8388608.0) * (2.0 ** (real'(b[30:23]) - 150.0));
    return b[31] ? -v : v;
  endfunction

  task automatic model(input logic [63:0] b, input logic dbl, input logic uns,
                       input logic [2:0] rmf, input logic [2:0] dyn,
                       output logic [63:0] r, output logic [4:0] f,
                       output logic we, output logic fwe, output logic err);
    logic [2:0] m;
    logic       exp_ones, frac_nz, sgn;
    real        v, fl, d, q, maxv, minv;
    longint     li;
    m = (rmf == 3'd7) ? dyn : rmf;
    r = 64'd0; f = 5'd0; we = 1'b0; fwe = 1'b0; err = 1'b0;
    if (m > 3'd4) begin err = 1'b1; return; end
    we = 1'b1;
    exp_ones = dbl ? (&b[62:52]) : (&b[30:23]);
    frac_nz  = dbl ? (|b[51:0]) : (|b[22:0]);
    sgn      = dbl ? b[63] : b[31];
    maxv = uns ? 4294967295.0 : 2147483647.0;
    minv = uns ? 0.0 : -2147483648.0;
    if (exp_ones && frac_nz) begin q = maxv; f = 5'h10; end
    else if (exp_ones) begin q = sgn ? minv : maxv; f = 5'h10; end
    else begin
      v = val_of(b, dbl);
      if (v >= maxv) begin q = maxv; f = 5'h10; end
      else if (v < minv) begin
        if (uns && v > -1.0) begin q = 0.0; f = 5'h01; end
        else begin q = minv; f = 5'h10; end
      end else begin
        fl = $floor(v);
        d  = v - fl;
        case (m)
          3'd0: q = (d > 0.5) ? fl + 1.0 : (d < 0.5) ? fl :
                    (($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0);
          3'd1: q = (v >= 0.0) ? fl : ((d > 0.0) ? fl + 1.0 : fl);
          3'd2: q = fl;
          3'd3: q = (d > 0.0) ? fl + 1.0 : fl;
          default: q = (d > 0.5) ? fl + 1.0 : (d < 0.5) ? fl :
                       ((v > 0.0) ? fl + 1.0 : fl);
        endcase
        if (d != 0.0) f = 5'h01;
      end
    end
    li  = longint'(q);
    r   = {{32{li[31]}}, li[31:0]};
    fwe = (f != 5'd0);
  endtask

  task automatic conv(input logic [63:0] b, input logic dbl, input logic uns,
                      input logic [2:0] rmf, input logic [2:0] dyn,
                      input string tag);
    logic [63:0] er;
    logic [4:0]  ef;
    logic        ewe, efwe, eerr;
    model(b, dbl, uns, rmf, dyn, er, ef, ewe, efwe, eerr);
    @(negedge clk);
    in_valid = 1'b1; op = b; fmt_dbl = dbl; is_unsigned = uns;
    rm_field = rmf; dyn_rm = dyn;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (res_we !== ewe || flags_we !== efwe || rm_err !== eerr ||
        (ewe && (result !== er || flags !== ef))) begin
      errors++;
      $display("FAIL %s op=%h dbl=%0d uns=%0d rm=%0d dyn=%0d: got res=%h fl=%b we=%b fwe=%b err=%b, expected res=%h fl=%b we=%b fwe=%b err=%b",
               tag, b, dbl, uns, rmf, dyn, result, flags, res_we, flags_we, rm_err,
               er, ef, ewe, efwe, eerr);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_we !== 1'b0 || flags_we !== 1'b0 || rm_err !== 1'b0) begin
      errors++;
      $display("FAIL %s strobes got we=%b fwe=%b err=%b, expected all 0",
               tag, res_we, flags_we, rm_err);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; fmt_dbl = 1'b1; is_unsigned = 1'b0;
    rm_field = 3'd0; dyn_rm = 3'd0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_we !== 1'b0 || flags_we !== 1'b0 || rm_err !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset strobes got we=%b fwe=%b err=%b, expected 0",
               res_we, flags_we, rm_err);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R1 NaN
    conv(64'h7FF8000000000000, 1, 0, 0, 0, "R1");
    conv(64'h000000007FC00000, 0, 1, 1, 0, "R1");
    conv(64'hFFF0000000000001, 1, 0, 3, 0, "R1");
    // R2 at or above maximum
    conv($realtobits(2147483647.0), 1, 0, 0, 0, "R2");
    conv($realtobits(1.0e10), 1, 1, 2, 0, "R2");
    conv($realtobits(4294967295.0), 1, 1, 0, 0, "R2");
    conv(64'h000000007F800000, 0, 0, 0, 0, "R2");
    conv($realtobits(2147483646.7), 1, 0, 3, 0, "R2");
    // R3 below minimum
    conv($realtobits(-3.0e9), 1, 0, 0, 0, "R3");
    conv($realtobits(-2147483648.5), 1, 0, 1, 0, "R3");
    conv($realtobits(-2147483648.0), 1, 0, 0, 0, "R3");
    conv($realtobits(-1.0), 1, 1, 0, 0, "R3");
    conv(64'hFFF0000000000000, 1, 1, 0, 0, "R3");
    conv(64'h00000000FF800000, 0, 0, 0, 0, "R3");
    // R4 small negative to unsigned
    conv($realtobits(-0.5), 1, 1, 2, 0, "R4");
    conv(64'h00000000BF400000, 0, 1, 0, 0, "R4");
    conv($realtobits(-1.0e-300), 1, 1, 3, 0, "R4");
    // R5 zeros
    conv(64'h0000000000000000, 1, 0, 0, 0, "R5");
    conv(64'h8000000000000000, 1, 1, 2, 0, "R5");
    conv(64'h0000000080000000, 0, 0, 3, 0, "R5");
    // R6 every mode on ties and fractions
    for (int m = 0; m < 5; m++) begin
      conv($realtobits(2.5), 1, 0, 3'(m), 0, "R6");
      conv($realtobits(-2.5), 1, 0, 3'(m), 0, "R6");
      conv($realtobits(3.5), 1, 0, 3'(m), 0, "R6");
      conv($realtobits(-0.3), 1, 0, 3'(m), 0, "R6");
      conv($realtobits(0.5), 1, 1, 3'(m), 0, "R6");
      conv($realtobits(1.0e-310), 1, 0, 3'(m), 0, "R6");
      conv(64'h0000000040600000, 0, 0, 3'(m), 0, "R6");
    end
    conv($realtobits(7.0), 1, 0, 0, 0, "R6");
    // R7 sign extension of unsigned results
    conv($realtobits(3.0e9), 1, 1, 0, 0, "R7");
    conv($realtobits(-5.0), 1, 0, 0, 0, "R7");
    // R9 dynamic mode
    conv($realtobits(2.7), 1, 0, 7, 1, "R9");
    conv($realtobits(2.2), 1, 0, 7, 3, "R9");
    conv($realtobits(-2.5), 1, 0, 7, 4, "R9");
    // R10 illegal modes
    conv($realtobits(2.5), 1, 0, 5, 0, "R10");
    conv($realtobits(2.5), 1, 0, 6, 0, "R10");
    conv($realtobits(2.5), 1, 0, 7, 5, "R10");
    conv($realtobits(2.5), 1, 0, 7, 7, "R10");
    // R11 idle
    idle_check("R11");
    conv($realtobits(1.5), 1, 0, 0, 0, "R11");
    idle_check("R11");
    // R12 single with garbage upper half
    conv(64'hDEADBEEF40600000, 0, 0, 0, 0, "R12");
    conv(64'hFFFFFFFFC0200000, 0, 1, 2, 0, "R12");
    // R8 flag layout, random mix
    for (int i = 0; i < 600; i++) begin
      real v;
      logic [63:0] b;
      logic        d;
      v = (real'($urandom) / 4294967296.0) * (2.0 ** real'($urandom % 36));
      if ($urandom % 2 == 1) v = -v;
      d = 1'($urandom % 4 != 0);
      b = $realtobits(v);
      if (!d) b = {$urandom, 1'b0, 8'(120 + $urandom % 40), 23'($urandom)};
      conv(b, d, 1'($urandom), 3'($urandom), 3'($urandom), "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule